// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block decouples code fetching from instruction execution. A fetch engine walks a byte address forward on its own. It keeps issuing single-byte memory reads while the queue has room for the data. Returned bytes land in a small circular buffer. On the other side, the execute stage pops them one at a time, so fetching and consuming overlap in the same cycle. When execution falls behind and the buffer fills, the read port goes quiet until a pop frees a slot.

A redirect input carries a new code address. It empties the buffer, restarts fetching at the new address and marks every read still in flight as stale. The block then drops those stale reads when they return. The execute side therefore sees nothing valid until the first byte from the new address has been written. That wait is the cost of a taken branch.

The memory port has no backpressure: every cycle in which `mem_req` is high issues one read of `mem_addr`. Data returns in issue order, with `mem_rvalid` high for one cycle, after a latency of one cycle or more.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is asserted and directly after it is released, `count` is 0, `empty` is 1, `out_valid` is 0, and `mem_req` is 1 with `mem_addr` equal to the RESET_VEC parameter.
- R2: Popped bytes are the memory contents of consecutive addresses, in order, starting at the reset vector or at the latest redirect target. `mem_addr` advances by exactly one after each cycle in which a read is issued.
- R3: A read is issued only while the free slots (DEPTH minus `count`) outnumber the live reads in flight. With the queue full and no pop, `count` equals DEPTH and `mem_req` stays low.
- R4: A pop and a byte write can happen in the same cycle. With memory latency 1 or 2, DEPTH 4 and a pop every cycle, a valid byte is delivered on every cycle of the steady state.
- R5: In the cycle after `flush` is high, `count` is 0, `empty` is 1 and `mem_addr` equals the `flush_addr` that was presented.
- R6: Reads issued before a flush whose data returns after it are never written into the queue. The first byte popped after a flush is the content of `flush_addr`.
- R7: After a flush cycle, `out_valid` stays low for exactly latency+1 cycles, then rises with the target's byte.
- R8: While `flush` is high, `out_valid` is 0 and an asserted `pop` consumes nothing.
- R9: `count` never exceeds DEPTH, and `empty` is 1 exactly when `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Issue a one-byte read this cycle |
| mem_addr | output | AW | Address of the read being issued |
| mem_rvalid | input | 1 | Read data returned this cycle (in issue order) |
| mem_rdata | input | 8 | Returned byte |
| flush | input | 1 | Discard queued and in-flight bytes, redirect fetch |
| flush_addr | input | AW | New fetch address taken with `flush` |
| pop | input | 1 | Execute side consumes the head byte |
| out_valid | output | 1 | Head byte is valid |
| out_byte | output | 8 | Head byte |
| count | output | $clog2(DEPTH+1) | Number of bytes held |
| empty | output | 1 | Queue holds no byte |

## Verification
Some properties are checked on every cycle. The assertions cover the bound on held bytes plus live reads, the idle bus whenever the buffer is full, the one-step address walk, and the cleared state and redirected address right after a flush. They also check that nothing is offered during a flush cycle or in the cycle after it. Other properties need scenarios. Only the bench shows that stale returns are really dropped and that the byte stream stays in address order across many pop patterns. It also shows the exact penalty length for each memory latency and the sustained one-byte-per-cycle rate that proves fetch and execute overlap.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DEPTH = 6,
  parameter int AW = 16,
  parameter logic [AW-1:0] RESET_VEC = '0,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(2 * DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [7:0]    mem_rdata,
  input  logic          flush,
  input  logic [AW-1:0] flush_addr,
  input  logic          pop,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  output logic [CW-1:0] count,
  output logic          empty
);

  logic [7:0]    slots [DEPTH];
  logic [IW-1:0] rd_ix, wr_ix;
  logic [CW-1:0] occ;
  logic [PW-1:0] pend, stale, live, free;
  logic [AW-1:0] fetch_pc;

  function automatic logic [IW-1:0] bump(input logic [IW-1:0] ix);
    return (ix == IW'(DEPTH - 1)) ? '0 : ix + 1'b1;
  endfunction

  wire drop  = (stale != '0);
  wire wr_en = mem_rvalid && !drop && !flush;
  wire rd_en = pop && out_valid;

  assign live      = pend - stale;
  assign free      = PW'(DEPTH) - PW'(occ);
  assign mem_req   = !flush && (free > live);
  assign mem_addr  = fetch_pc;
  assign out_valid = (occ != '0) && !flush;
  assign out_byte  = slots[rd_ix];
  assign count     = occ;
  assign empty     = (occ == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ix    <= '0;
      wr_ix    <= '0;
      occ      <= '0;
      pend     <= '0;
      stale    <= '0;
      fetch_pc <= RESET_VEC;
    end else begin
      pend <= pend + PW'(mem_req) - PW'(mem_rvalid);
      if (flush) begin
        stale    <= pend - PW'(mem_rvalid);
        occ      <= '0;
        rd_ix    <= '0;
        wr_ix    <= '0;
        fetch_pc <= flush_addr;
      end else begin
        if (mem_rvalid && drop) stale <= stale - 1'b1;
        if (wr_en) wr_ix <= bump(wr_ix);
        if (rd_en) rd_ix <= bump(rd_ix);
        occ <= occ + CW'(wr_en) - CW'(rd_en);
        if (mem_req) fetch_pc <= fetch_pc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_ix] <= mem_rdata;
  end

endmodule

// File: rtl/prefetch_queue_chk.sv
module prefetch_queue_chk #(
  parameter int DEPTH = 6,
  parameter int AW = 16,
  parameter int CW = 3,
  parameter int PW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic [AW-1:0] flush_addr,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          out_valid,
  input logic [CW-1:0] count,
  input logic [PW-1:0] live
);

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> count == '0); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !flush) |=> mem_addr == $past(mem_addr) + 1'b1); // R2

  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) + int'(live) <= DEPTH); // R3

  AST_IDLE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) == DEPTH) |-> !mem_req); // R3

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && mem_addr == $past(flush_addr))); // R5

  AST_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid); // R7

  AST_FLUSH_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !out_valid); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH); // R9

endmodule

bind prefetch_queue prefetch_queue_chk #(
  .DEPTH(DEPTH), .AW(AW), .CW(CW), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
  .mem_req(mem_req), .mem_addr(mem_addr), .out_valid(out_valid),
  .count(count), .live(live)
);

// File: tb/sim_prefetch_queue.sv
module sim_prefetch_queue;
  localparam int P = 10;
  localparam int DEPTH = 4;
  localparam int AW = 16;
  localparam logic [AW-1:0] RV = 16'h01FE;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic mem_req, mem_rvalid, flush = 0, pop = 0, out_valid, empty;
  logic [AW-1:0] mem_addr, flush_addr = '0;
  logic [7:0] mem_rdata, out_byte;
  logic [CW-1:0] count;

  int tests = 0, fails = 0, lat = 1, npop = 0;
  logic [AW-1:0] exp_a;
  logic [7:0] lfsr = 8'h5B;
  logic last_v;
  bit done = 0;

  always #(P/2) clk = ~clk;

  prefetch_queue #(.DEPTH(DEPTH), .AW(AW), .RESET_VEC(RV)) u0 (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .flush(flush),
    .flush_addr(flush_addr), .pop(pop), .out_valid(out_valid),
    .out_byte(out_byte), .count(count), .empty(empty));

  function automatic logic [7:0] fb(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  logic [7:0] pv;
  logic [AW-1:0] pa [8];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= '0;
    else pv <= {pv[6:0], mem_req};
  end
  always_ff @(posedge clk) begin
    pa[0] <= mem_addr;
    for (int i = 1; i < 8; i++) pa[i] <= pa[i-1];
  end
  assign mem_rvalid = pv[lat-1];
  assign mem_rdata  = fb(pa[lat-1]);

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step(input logic p, input logic f, input logic [AW-1:0] t);
    @(negedge clk);
    pop = p; flush = f; flush_addr = t;
    #(P/4);
    last_v = out_valid;
    if (f && p) chk(out_valid == 1'b0, "R8 pop during flush", out_valid, 0);
    if (p && out_valid && !f) begin
      chk(out_byte == fb(exp_a), "R2 byte order", out_byte, fb(exp_a));
      exp_a = exp_a + 1'b1;
      npop++;
    end
    if (f) exp_a = t;
  endtask

  task automatic stall_check();
    for (int i = 0; i < 14; i++) step(0, 0, '0);
    chk(int'(count) == DEPTH, "R3 full count", count, DEPTH);
    chk(mem_req == 1'b0, "R3 bus idle when full", mem_req, 0);
    chk(empty == 1'b0, "R9 empty flag when full", empty, 0);
  endtask

  task automatic flush_check(input logic [AW-1:0] t, input logic p);
    int first;
    first = 0;
    step(p, 1, t);
    for (int k = 1; k <= 8; k++) begin
      step(0, 0, '0);
      if (k == 1) begin
        chk(count == '0 && empty, "R5 cleared after flush", count, 0);
        chk(mem_addr == t, "R5 redirect address", mem_addr, t);
      end
      if (last_v && first == 0) first = k;
    end
    chk(first == lat + 2, "R7 branch penalty", first - 1, lat + 1);
    step(1, 0, '0);
    chk(exp_a == t + 1'b1, "R6 first byte from target", exp_a, t + 1'b1);
  endtask

  task automatic stream(input int mode, input int n, output int got);
    logic p;
    got = 0;
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: p = 1'b1;
        1: p = i[0];
        2: p = (i % 3 == 0);
        default: p = lfsr[0];
      endcase
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(p, 0, '0);
      if (i >= 10 && p && last_v) got++;
    end
  endtask

  initial begin
    int got;
    exp_a = RV;
    #(P*3 + P/2);
    #1;
    chk(count == '0 && empty, "R1 reset empty", count, 0);
    chk(out_valid == 1'b0, "R1 no valid byte", out_valid, 0);
    chk(mem_req == 1'b1 && mem_addr == RV, "R1 reset vector fetch", mem_addr, RV);
    @(negedge clk); rst_n = 1;
    #1;
    chk(mem_req == 1'b1 && mem_addr == RV, "R1 after release", mem_addr, RV);
    stall_check();
    for (int l = 1; l <= 3; l++) begin
      stall_check();
      lat = l;
      flush_check(16'h2000 + AW'(l * 16'h0111), 0);
      for (int m = 0; m < 4; m++) begin
        stall_check();
        stream(m, 60, got);
        if (m == 0 && l <= 2)
          chk(got == 50, "R4 one byte per cycle", got, 50);
        chk(int'(count) <= DEPTH && (empty == (count == '0)), "R9 occupancy", count, DEPTH);
      end
      stream(0, 12, got);
      flush_check(16'h40F0 + AW'(l), 1);
      stream(1, 30, got);
      stream(0, 12, got);
      flush_check(16'hFFFE, 0);
      stream(3, 30, got);
    end
    chk(npop > 500, "R2 bytes consumed", npop, 500);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(P*150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule